// File: doc/BRIEF.md
# Tagged branch target buffer

This block sits in the fetch stage and picks the address to fetch next. In every cycle it splits the current program counter into a table index and a tag. It reads one entry of a direct-mapped table and decides whether to redirect fetch to a stored target or to continue with the sequential address. Each entry holds a valid bit, a tag, a target address and a one-bit flag that records whether the branch went taken the last time it ran. A matching tag on its own does not redirect fetch. The flag must also say taken.

The execute stage reports each resolved branch through a resolve port. If the resolved branch is already in the table, only its direction flag is overwritten. If it is not, the entry at its index is claimed for it and any earlier occupant is evicted. Program counters are 4-byte aligned, so the two lowest address bits take no part in indexing or tagging. The table depth (a power of two) and the address width are parameters. A further option selects whether tag and target storage are cleared on reset as well as the valid bits.

Top module: `btb_next_addr`

## Requirements
- R1: After reset every entry is invalid, so every lookup reports `pred_hit`=0 and `next_pc` = `fetch_pc`+4.
- R2: The entry index is `pc[IDX_W+1:2]` and the tag is `pc[PC_W-1:IDX_W+2]`. Two addresses that share an index but differ in the tag never hit on each other's entry.
- R3: `next_pc` equals the stored target only when `pred_hit`=1 and `pred_taken`=1. In every other case it equals `fetch_pc`+4. `pred_taken` is never 1 without `pred_hit`.
- R4: A resolve whose address misses in the table writes the tag, the target and the actual direction into the entry at its index and marks the entry valid.
- R5: A resolve whose address hits overwrites only the direction flag with the actual outcome. The stored tag and target are unchanged, even when the resolve carries a different target.
- R6: When a resolve and a lookup address the same entry in the same cycle, the lookup sees the entry as it was before the write. The new contents are seen from the next cycle on.
- R7: When a resolve misses and the entry at its index holds another branch, that branch is evicted, and a later lookup of its address misses.
- R8: For a loop branch that runs N>=3 iterations per visit, the prediction is wrong exactly twice per visit once the entry is warm: on the first iteration and on the last.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_pc | input | PC_W | Address being fetched this cycle |
| next_pc | output | PC_W | Predicted address for the next fetch |
| pred_hit | output | 1 | Lookup found a valid entry with matching tag |
| pred_taken | output | 1 | Lookup hit and the entry's flag says taken |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | PC_W | Address of the resolved branch |
| res_target | input | PC_W | Target observed for the resolved branch |
| res_taken | input | 1 | Actual direction of the resolved branch |

## Verification
A corrupted valid bit or tag shows at the ports in the same cycle that its index is looked up. It appears as a wrong `pred_hit` and a `next_pc` that falls back to, or leaves, the sequential address. A stale or wrongly written direction flag flips `pred_taken` on the next lookup of that branch. A target overwritten on a hit stays hidden until the flag next says taken, and then `next_pc` shows the wrong address. The bench therefore checks every index right after each kind of write. It also drives a loop pattern, so that a wrong flag update shows up as a misprediction count other than two per visit.

// File: rtl/btb_pkg.sv
package btb_pkg;
   localparam int unsigned INSN_BYTES = 4;
   localparam int unsigned ALIGN_W    = 2;

   typedef enum logic [1:0] {
      LK_MISS   = 2'b00,
      LK_HIT_NT = 2'b01,
      LK_HIT_TK = 2'b11
   } lookup_e;

   typedef enum logic [1:0] {
      WR_NONE  = 2'b00,
      WR_FLAG  = 2'b01,
      WR_ALLOC = 2'b10
   } wr_kind_e;
endpackage

// File: rtl/btb_pc_split.sv
module btb_pc_split #(
   parameter int unsigned PC_W  = 32,
   parameter int unsigned IDX_W = 6,
   parameter int unsigned TAG_W = 24
) (
   input  logic [PC_W-1:0]  pc,
   output logic [IDX_W-1:0] idx,
   output logic [TAG_W-1:0] tag
);
   import btb_pkg::*;

   if (IDX_W + TAG_W + ALIGN_W != PC_W) begin : g_bad_split
      $error("btb_pc_split: index, tag and alignment widths do not cover the PC");
   end

   assign idx = pc[ALIGN_W +: IDX_W];
   assign tag = pc[PC_W-1 -: TAG_W];
endmodule

// File: rtl/btb_store.sv
module btb_store #(
   parameter int unsigned PC_W       = 32,
   parameter int unsigned ENTRIES    = 64,
   parameter int unsigned IDX_W      = 6,
   parameter int unsigned TAG_W      = 24,
   parameter bit          CLEAR_DATA = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [IDX_W-1:0]   rd_a_idx,
   output logic               rd_a_valid,
   output logic [TAG_W-1:0]   rd_a_tag,
   output logic [PC_W-1:0]    rd_a_target,
   output logic               rd_a_dir,
   input  logic [IDX_W-1:0]   rd_b_idx,
   output logic               rd_b_valid,
   output logic [TAG_W-1:0]   rd_b_tag,
   input  btb_pkg::wr_kind_e  wr_kind,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [TAG_W-1:0]   wr_tag,
   input  logic [PC_W-1:0]    wr_target,
   input  logic               wr_dir
);
   import btb_pkg::*;

   logic [ENTRIES-1:0] vld_vec;
   logic [ENTRIES-1:0] dir_vec;
   logic [TAG_W-1:0]   tag_arr [ENTRIES];
   logic [PC_W-1:0]    tgt_arr [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic             sel;
      logic             any_wr;
      logic             alloc_wr;
      logic             v_q;
      logic             d_q;
      logic [TAG_W-1:0] t_q;
      logic [PC_W-1:0]  g_q;

      assign sel      = (wr_idx == IDX_W'(e));
      assign any_wr   = sel && (wr_kind != WR_NONE);
      assign alloc_wr = sel && (wr_kind == WR_ALLOC);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            d_q <= 1'b0;
         end else begin
            if (any_wr)   d_q <= wr_dir;
            if (alloc_wr) v_q <= 1'b1;
         end
      end

      if (CLEAR_DATA) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               t_q <= '0;
               g_q <= '0;
            end else if (alloc_wr) begin
               t_q <= wr_tag;
               g_q <= wr_target;
            end
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (alloc_wr) begin
               t_q <= wr_tag;
               g_q <= wr_target;
            end
         end
      end

      assign vld_vec[e] = v_q;
      assign dir_vec[e] = d_q;
      assign tag_arr[e] = t_q;
      assign tgt_arr[e] = g_q;
   end

   assign rd_a_valid  = vld_vec[rd_a_idx];
   assign rd_a_dir    = dir_vec[rd_a_idx];
   assign rd_a_tag    = tag_arr[rd_a_idx];
   assign rd_a_target = tgt_arr[rd_a_idx];
   assign rd_b_valid  = vld_vec[rd_b_idx];
   assign rd_b_tag    = tag_arr[rd_b_idx];
endmodule

// File: rtl/btb_lookup.sv
module btb_lookup #(
   parameter int unsigned PC_W  = 32,
   parameter int unsigned TAG_W = 24
) (
   input  logic [PC_W-1:0]  fetch_pc,
   input  logic [TAG_W-1:0] pc_tag,
   input  logic             ent_valid,
   input  logic [TAG_W-1:0] ent_tag,
   input  logic [PC_W-1:0]  ent_target,
   input  logic             ent_dir,
   output logic [PC_W-1:0]  next_pc,
   output logic             hit,
   output logic             taken
);
   import btb_pkg::*;

   lookup_e         kind;
   logic [PC_W-1:0] seq_pc;

   assign seq_pc = fetch_pc + PC_W'(INSN_BYTES);

   always_comb begin
      if (!(ent_valid && (ent_tag == pc_tag))) kind = LK_MISS;
      else if (ent_dir)                        kind = LK_HIT_TK;
      else                                     kind = LK_HIT_NT;
   end

   always_comb begin
      unique case (kind)
         LK_HIT_TK: next_pc = ent_target;
         default:   next_pc = seq_pc;
      endcase
   end

   assign hit   = (kind != LK_MISS);
   assign taken = (kind == LK_HIT_TK);
endmodule

// File: rtl/btb_next_addr.sv
module btb_next_addr #(
   parameter int unsigned PC_W       = 32,
   parameter int unsigned ENTRIES    = 64,
   parameter bit          CLEAR_DATA = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] fetch_pc,
   output logic [PC_W-1:0] next_pc,
   output logic            pred_hit,
   output logic            pred_taken,
   input  logic            res_valid,
   input  logic [PC_W-1:0] res_pc,
   input  logic [PC_W-1:0] res_target,
   input  logic            res_taken
);
   import btb_pkg::*;

   localparam int unsigned IDX_W = $clog2(ENTRIES);
   localparam int unsigned TAG_W = PC_W - IDX_W - ALIGN_W;

   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_depth
      $error("btb_next_addr: ENTRIES must be a power of two of at least 2");
   end
   if (PC_W <= IDX_W + ALIGN_W) begin : g_bad_width
      $error("btb_next_addr: PC_W leaves no tag bits");
   end

   logic [IDX_W-1:0] f_idx, r_idx;
   logic [TAG_W-1:0] f_tag, r_tag;
   logic             a_valid, a_dir, b_valid;
   logic [TAG_W-1:0] a_tag, b_tag;
   logic [PC_W-1:0]  a_target;
   logic             res_hit;
   wr_kind_e         wr_kind;

   btb_pc_split #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_split_f (
      .pc (fetch_pc), .idx(f_idx), .tag(f_tag)
   );

   btb_pc_split #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_split_r (
      .pc (res_pc), .idx(r_idx), .tag(r_tag)
   );

   assign res_hit = b_valid && (b_tag == r_tag);

   always_comb begin
      if (!res_valid)   wr_kind = WR_NONE;
      else if (res_hit) wr_kind = WR_FLAG;
      else              wr_kind = WR_ALLOC;
   end

   btb_store #(
      .PC_W(PC_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W),
      .CLEAR_DATA(CLEAR_DATA)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_a_idx   (f_idx),
      .rd_a_valid (a_valid),
      .rd_a_tag   (a_tag),
      .rd_a_target(a_target),
      .rd_a_dir   (a_dir),
      .rd_b_idx   (r_idx),
      .rd_b_valid (b_valid),
      .rd_b_tag   (b_tag),
      .wr_kind    (wr_kind),
      .wr_idx     (r_idx),
      .wr_tag     (r_tag),
      .wr_target  (res_target),
      .wr_dir     (res_taken)
   );

   btb_lookup #(.PC_W(PC_W), .TAG_W(TAG_W)) u_lookup (
      .fetch_pc  (fetch_pc),
      .pc_tag    (f_tag),
      .ent_valid (a_valid),
      .ent_tag   (a_tag),
      .ent_target(a_target),
      .ent_dir   (a_dir),
      .next_pc   (next_pc),
      .hit       (pred_hit),
      .taken     (pred_taken)
   );
endmodule

// File: rtl/btb_next_addr_chk.sv
module btb_next_addr_chk #(
   parameter int unsigned PC_W    = 32,
   parameter int unsigned ENTRIES = 64
) (
   input logic            clk,
   input logic            rst_n,
   input logic [PC_W-1:0] fetch_pc,
   input logic [PC_W-1:0] next_pc,
   input logic            pred_hit,
   input logic            pred_taken,
   input logic            res_valid,
   input logic [PC_W-1:0] res_pc,
   input logic [PC_W-1:0] res_target,
   input logic            res_taken
);
   logic unused_ok;
   assign unused_ok = ^{res_target, ENTRIES[0]};

   // R3: a taken prediction always comes with a hit
   a_r3_taken_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
      pred_taken |-> pred_hit);

   // R3: without a taken hit, fetch continues sequentially
   a_r3_fallback_seq: assert property (@(posedge clk) disable iff (!rst_n)
      !pred_taken |-> (next_pc == fetch_pc + PC_W'(4)));

   // R6: a resolve of the address being fetched is seen on the next cycle
   a_r6_visible_next: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_pc == fetch_pc) |=>
         (($past(fetch_pc) != fetch_pc) ||
          (pred_hit && (pred_taken == $past(res_taken)))));

   // R5: a taken hit that resolves taken keeps the same target
   a_r5_target_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_taken && res_pc == fetch_pc && pred_taken) |=>
         (($past(fetch_pc) != fetch_pc) || (next_pc == $past(next_pc))));
endmodule

bind btb_next_addr btb_next_addr_chk #(.PC_W(PC_W), .ENTRIES(ENTRIES)) u_chk (.*);

// File: tb/btb_next_addr_tb.sv
module btb_next_addr_tb;
   localparam int PC_W       = 16;
   localparam int ENTRIES    = 8;
   localparam int IDX_W      = $clog2(ENTRIES);
   localparam int CLK_PERIOD = 10;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [PC_W-1:0] fetch_pc = '0;
   logic [PC_W-1:0] next_pc;
   logic            pred_hit, pred_taken;
   logic            res_valid = 1'b0;
   logic [PC_W-1:0] res_pc = '0;
   logic [PC_W-1:0] res_target = '0;
   logic            res_taken = 1'b0;

   int n_checks = 0;
   int n_err    = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   btb_next_addr #(.PC_W(PC_W), .ENTRIES(ENTRIES)) u_dut (
      .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .next_pc(next_pc),
      .pred_hit(pred_hit), .pred_taken(pred_taken), .res_valid(res_valid),
      .res_pc(res_pc), .res_target(res_target), .res_taken(res_taken)
   );

   function automatic logic [PC_W-1:0] mk_pc(int tag, int idx);
      return PC_W'((tag << (IDX_W + 2)) | (idx << 2));
   endfunction

   function automatic logic [PC_W-1:0] tgt_of(int idx);
      return PC_W'(32'h8000 + idx * 64 + 4);
   endfunction

   task automatic chk(string req, string what, logic [PC_W-1:0] act, logic [PC_W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic look(logic [PC_W-1:0] pc);
      @(negedge clk);
      fetch_pc = pc;
      #1;
   endtask

   task automatic expect_out(string req, logic h, logic t, logic [PC_W-1:0] nxt);
      chk(req, "pred_hit", PC_W'(pred_hit), PC_W'(h));
      chk(req, "pred_taken", PC_W'(pred_taken), PC_W'(t));
      chk(req, "next_pc", next_pc, nxt);
   endtask

   task automatic resolve(logic [PC_W-1:0] pc, logic [PC_W-1:0] tgt, logic tk);
      @(negedge clk);
      res_valid = 1'b1; res_pc = pc; res_target = tgt; res_taken = tk;
      @(negedge clk);
      res_valid = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++; n_err++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: every index under several tags misses after reset
      for (int t = 0; t < 4; t++)
         for (int i = 0; i < ENTRIES; i++) begin
            look(mk_pc(t * 5 + 1, i));
            expect_out("R1", 1'b0, 1'b0, mk_pc(t * 5 + 1, i) + PC_W'(4));
         end

      // R4: allocate every index with tag 5, taken when i%3 != 0
      for (int i = 0; i < ENTRIES; i++)
         resolve(mk_pc(5, i), tgt_of(i), (i % 3) != 0);
      for (int i = 0; i < ENTRIES; i++) begin
         logic tk;
         tk = (i % 3) != 0;
         look(mk_pc(5, i));
         expect_out("R4", 1'b1, tk, tk ? tgt_of(i) : mk_pc(5, i) + PC_W'(4));
      end

      // R2: same index, other tag misses; R3 sequential fallback
      for (int i = 0; i < ENTRIES; i++) begin
         look(mk_pc(6, i));
         expect_out("R2", 1'b0, 1'b0, mk_pc(6, i) + PC_W'(4));
      end

      // R7: allocation by an aliasing branch evicts the old one
      resolve(mk_pc(6, 2), PC_W'(16'h4440), 1'b1);
      look(mk_pc(5, 2));
      expect_out("R7", 1'b0, 1'b0, mk_pc(5, 2) + PC_W'(4));
      look(mk_pc(6, 2));
      expect_out("R7", 1'b1, 1'b1, PC_W'(16'h4440));

      // R5: hit updates only the flag; target is kept
      resolve(mk_pc(5, 4), PC_W'(16'h1230), 1'b0);
      look(mk_pc(5, 4));
      expect_out("R5", 1'b1, 1'b0, mk_pc(5, 4) + PC_W'(4));
      resolve(mk_pc(5, 4), PC_W'(16'h5670), 1'b1);
      look(mk_pc(5, 4));
      expect_out("R5", 1'b1, 1'b1, tgt_of(4));

      // R6: same-cycle write is not seen until the next cycle
      look(mk_pc(9, 6));
      res_valid = 1'b1; res_pc = mk_pc(9, 6); res_target = PC_W'(16'h2220); res_taken = 1'b1;
      #1;
      expect_out("R6", 1'b0, 1'b0, mk_pc(9, 6) + PC_W'(4));
      @(negedge clk);
      res_valid = 1'b0;
      #1;
      expect_out("R6", 1'b1, 1'b1, PC_W'(16'h2220));
      @(negedge clk);
      res_valid = 1'b1; res_taken = 1'b0;
      #1;
      expect_out("R6", 1'b1, 1'b1, PC_W'(16'h2220));
      @(negedge clk);
      res_valid = 1'b0;
      #1;
      expect_out("R6", 1'b1, 1'b0, mk_pc(9, 6) + PC_W'(4));

      // R8: loop branch, several trip counts, two misses per warm visit
      for (int n = 3; n <= 6; n++) begin
         logic [PC_W-1:0] br;
         br = mk_pc(20 + n, 1);
         for (int v = 0; v < 3; v++) begin
            int miss;
            miss = 0;
            for (int it = 0; it < n; it++) begin
               logic act;
               act = (it < n - 1);
               look(br);
               if (pred_taken != act) miss++;
               if (pred_taken)
                  chk("R8", "loop next_pc", next_pc, PC_W'(16'h0100));
               res_valid = 1'b1; res_pc = br; res_target = PC_W'(16'h0100); res_taken = act;
               @(negedge clk);
               res_valid = 1'b0;
            end
            if (v > 0) chk("R8", "mispredicts per visit", PC_W'(miss), PC_W'(2));
         end
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
   end
endmodule